// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

The sequencer sits between a dataflow fabric and a single memory port. Loads, stores and memory no-ops reach it in any order. Each carries a wave number and three links: its own sequence number, the sequence number of the operation before it, and the sequence number of the one after it. Either neighbour link may hold a wildcard when a branch leaves that neighbour open. The block keeps up to eight requests in a small buffer. It remembers the wave being ordered and both links of the operation it issued last. It releases a request once the link chain proves that the request comes next.

A request comes next when the last issued operation names it as its successor, or when its own predecessor link names the last issued operation. The request must also belong to the current wave. A no-op moves the ordering state forward without touching memory. The request flagged as the end of its wave closes that wave. The block then moves on to the next wave number and restarts ordering from the start value, so the same sequence numbers can be reused in every wave.

Top module: `wom_sequencer`

## Requirements
- R1: After reset, in_ready is 1 and mem_valid is 0, the expected wave is 0, the last issued sequence number is 0, and the last successor link is the wildcard.
- R2: A buffered request of the current wave whose predecessor link equals the last issued sequence number becomes eligible. The first request of a wave has predecessor 0.
- R3: A buffered request of the current wave whose sequence number equals the successor link of the last issued request becomes eligible, even when its own predecessor link is the wildcard.
- R4: The wildcard is the all-ones value (63 for 6-bit links) and never matches anything. A request whose only usable link cannot yet be matched stays buffered, and mem_valid stays 0.
- R5: Requests that arrive out of order leave the memory port strictly in link order, one per cycle at most.
- R6: A request with op code 2 (no-op; code 3 is treated the same) is consumed once eligible. It updates the ordering state and never raises mem_valid.
- R7: A request whose wave differs from the expected wave waits. When a request with the end-of-wave flag is issued, the expected wave increments, the last sequence number resets to 0 and the last successor link resets to the wildcard.
- R8: The buffer holds 8 requests. in_ready is 0 exactly when all 8 entries are occupied.
- R9: While mem_valid is 1 and mem_ready is 0, mem_valid stays 1 and mem_addr, mem_data and mem_tag hold their values.
- R10: Op code 0 is a load (mem_is_store=0) and op code 1 is a store (mem_is_store=1). The address, data and tag of the request appear unchanged on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered by the fabric |
| in_ready | output | 1 | A free buffer entry exists |
| in_op | input | 2 | 0 load, 1 store, 2 or 3 no-op |
| in_wave | input | 8 | Wave number |
| in_seq | input | 6 | Own sequence number (never the wildcard) |
| in_pred | input | 6 | Predecessor link or wildcard |
| in_succ | input | 6 | Successor link or wildcard |
| in_eow | input | 1 | Last request of its wave |
| in_addr | input | 16 | Memory address |
| in_data | input | 32 | Store data |
| in_tag | input | 4 | Tag returned with the issued request |
| mem_valid | output | 1 | Request presented to memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_is_store | output | 1 | 1 for a store, 0 for a load |
| mem_addr | output | 16 | Address of the issued request |
| mem_data | output | 32 | Data of the issued request |
| mem_tag | output | 4 | Tag of the issued request |

## Verification
A plain chain that arrives reversed shows that order comes from the predecessor links and not from arrival order. A branchy wave with wildcard links, a no-op and a request from the next wave that arrives early separates successor-link matching from predecessor-link matching. The same wave shows that no-ops stay off the port and that a wave change is gated on the end-of-wave flag. A long chain held behind a stalled memory port fills the buffer and checks that the port holds its values under backpressure, and then that the chain drains in order.

// File: rtl/wom_pkg.sv
package wom_pkg;
    parameter int WAVE_W = 8;
    parameter int SEQ_W  = 6;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 4;

    localparam logic [SEQ_W-1:0] SEQ_WILD  = '1;
    localparam logic [SEQ_W-1:0] SEQ_START = '0;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_NOP   = 2'd2,
        OP_NOP2  = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [WAVE_W-1:0] wave;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  pred;
        logic [SEQ_W-1:0]  succ;
        logic              eow;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } mreq_t;
endpackage

// File: rtl/wom_link_match.sv
module wom_link_match
    import wom_pkg::*;
(
    input  logic              slot_vld,
    input  mreq_t             slot,
    input  logic [WAVE_W-1:0] cur_wave,
    input  logic [SEQ_W-1:0]  last_seq,
    input  logic [SEQ_W-1:0]  last_succ,
    output logic              hit
);
    logic by_pred;
    logic by_succ;

    always_comb begin
        by_pred = (slot.pred != SEQ_WILD) && (slot.pred == last_seq);
        by_succ = (last_succ != SEQ_WILD) && (slot.seq == last_succ);
        hit     = slot_vld && (slot.wave == cur_wave) && (by_pred || by_succ);
    end
endmodule

// File: rtl/wom_pick.sv
module wom_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wom_sequencer.sv
module wom_sequencer
    import wom_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [WAVE_W-1:0] in_wave,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [SEQ_W-1:0]  in_pred,
    input  logic [SEQ_W-1:0]  in_succ,
    input  logic              in_eow,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_is_store,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [TAG_W-1:0]  mem_tag
);
    typedef struct packed {
        logic [DEPTH-1:0]  vld;
        mreq_t [DEPTH-1:0] ent;
        logic [WAVE_W-1:0] wave;
        logic [SEQ_W-1:0]  last_seq;
        logic [SEQ_W-1:0]  last_succ;
    } state_t;

    state_t q, d;

    logic [DEPTH-1:0] hit;
    logic             sel_found, free_found;
    logic [IW-1:0]    sel_idx, free_idx;
    mreq_t            sel, incoming;
    logic             sel_nop, fire, accept;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        wom_link_match u_match (
            .slot_vld (q.vld[g]),
            .slot     (q.ent[g]),
            .cur_wave (q.wave),
            .last_seq (q.last_seq),
            .last_succ(q.last_succ),
            .hit      (hit[g])
        );
    end

    wom_pick #(.N(DEPTH)) u_pick_issue (
        .req  (hit),
        .found(sel_found),
        .idx  (sel_idx)
    );

    wom_pick #(.N(DEPTH)) u_pick_free (
        .req  (~q.vld),
        .found(free_found),
        .idx  (free_idx)
    );

    always_comb begin
        incoming      = '0;
        incoming.op   = op_e'(in_op);
        incoming.wave = in_wave;
        incoming.seq  = in_seq;
        incoming.pred = in_pred;
        incoming.succ = in_succ;
        incoming.eow  = in_eow;
        incoming.addr = in_addr;
        incoming.data = in_data;
        incoming.tag  = in_tag;

        sel          = q.ent[sel_idx];
        sel_nop      = sel.op[1];
        mem_valid    = sel_found && !sel_nop;
        mem_is_store = (sel.op == OP_STORE);
        mem_addr     = sel.addr;
        mem_data     = sel.data;
        mem_tag      = sel.tag;
        fire         = sel_found && (sel_nop || mem_ready);

        in_ready = free_found;
        accept   = in_valid && free_found;

        d = q;
        if (fire) begin
            d.vld[sel_idx] = 1'b0;
            if (sel.eow) begin
                d.wave      = q.wave + 1'b1;
                d.last_seq  = SEQ_START;
                d.last_succ = SEQ_WILD;
            end else begin
                d.last_seq  = sel.seq;
                d.last_succ = sel.succ;
            end
        end
        if (accept) begin
            d.vld[free_idx] = 1'b1;
            d.ent[free_idx] = incoming;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.vld       <= '0;
            q.ent       <= '0;
            q.wave      <= '0;
            q.last_seq  <= SEQ_START;
            q.last_succ <= SEQ_WILD;
        end else begin
            q <= d;
        end
    end

    // R9: a stalled request stays on the port unchanged
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_tag)));

    // R7: only the expected wave reaches memory
    p_wave_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (sel.wave == q.wave));

    // R8: backpressure only when every entry is taken
    p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (&q.vld));

    // R8: an accepted request with no issue grows occupancy by one
    p_occupancy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fire) |=> ($countones(q.vld) == $past($countones(q.vld)) + 1));

    // R5: well-formed links never make two entries eligible at once
    p_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/tb_wom_sequencer.sv
module tb_wom_sequencer;
    localparam logic [5:0] W = 6'h3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [7:0]  in_wave = '0;
    logic [5:0]  in_seq = '0, in_pred = '0, in_succ = '0;
    logic        in_eow = 1'b0;
    logic [15:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_tag = '0;
    logic        mem_valid, mem_is_store;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_tag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct { logic [3:0] tag; logic st; string req; } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    wom_sequencer dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [7:0] wv, input logic [5:0] s,
                        input logic [5:0] p, input logic [5:0] n, input logic e,
                        input logic [3:0] tg);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_wave = wv; in_seq = s; in_pred = p;
        in_succ = n; in_eow = e; in_tag = tg;
        in_addr = 16'h1000 + 16'(tg); in_data = 32'hD000_0000 + 32'(tg);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input logic [3:0] tg, input logic st, input string req);
        exp_t e;
        e.tag = tg; e.st = st; e.req = req;
        sb.push_back(e);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit && sb.size() != 0; i++) @(negedge clk);
        check(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    endtask

    // monitor: sample a quarter period after the falling edge
    always begin
        @(negedge clk);
        #5;
        if (rst_n && mem_valid && mem_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected issue tag", mem_tag, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(mem_tag == e.tag, e.req, "issue order tag", mem_tag, e.tag);
                check(mem_is_store == e.st, "R10", "op kind", mem_is_store, e.st);
                check(mem_addr == 16'h1000 + 16'(e.tag) && mem_data == 32'hD000_0000 + 32'(e.tag),
                      "R10", "addr/data", mem_addr, 16'h1000 + 16'(e.tag));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] held_addr;
        logic [3:0]  held_tag;
        repeat (3) @(negedge clk);
        #5;
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);
        rst_n = 1'b1;

        // wave 0: reversed chain, R2 and R5
        expect_out(4'd1, 1'b0, "R2");
        expect_out(4'd2, 1'b1, "R5");
        expect_out(4'd3, 1'b0, "R5");
        send(2'd0, 8'd0, 6'd3, 6'd2, W, 1'b1, 4'd3);
        repeat (2) @(negedge clk);
        #5;
        check(mem_valid == 1'b0, "R4", "late link waits", mem_valid, 0);
        send(2'd1, 8'd0, 6'd2, 6'd1, 6'd3, 1'b0, 4'd2);
        send(2'd0, 8'd0, 6'd1, 6'd0, 6'd2, 1'b0, 4'd1);
        drain(50);

        // wave 1 with wildcards and a no-op, wave 2 arriving early (R3 R4 R6 R7)
        expect_out(4'd5, 1'b1, "R2");
        expect_out(4'd7, 1'b0, "R3");
        expect_out(4'd8, 1'b1, "R6");
        expect_out(4'd9, 1'b0, "R7");
        send(2'd0, 8'd2, 6'd1, 6'd0, W, 1'b1, 4'd9);
        repeat (2) @(negedge clk);
        #5;
        check(mem_valid == 1'b0, "R7", "future wave waits", mem_valid, 0);
        send(2'd0, 8'd1, 6'd4, W, 6'd5, 1'b0, 4'd7);
        send(2'd1, 8'd1, 6'd5, 6'd4, W, 1'b1, 4'd8);
        send(2'd2, 8'd1, 6'd2, 6'd1, 6'd4, 1'b0, 4'd6);
        repeat (3) @(negedge clk);
        #5;
        check(mem_valid == 1'b0, "R4", "wildcard links wait", mem_valid, 0);
        send(2'd1, 8'd1, 6'd1, 6'd0, W, 1'b0, 4'd5);
        drain(50);

        // wave 3: eight-entry chain behind a stalled port (R8 R9)
        mem_ready = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            send(2'(k % 2), 8'd3, 6'(k), 6'(k - 1), (k == 8) ? W : 6'(k + 1),
                 (k == 8), 4'(k + 1));
        end
        #5;
        check(in_ready == 1'b0, "R8", "full buffer backpressure", in_ready, 0);
        check(mem_valid == 1'b1 && mem_tag == 4'd2, "R9", "head presented", mem_tag, 2);
        held_addr = mem_addr;
        held_tag  = mem_tag;
        repeat (3) @(negedge clk);
        #5;
        check(mem_valid && mem_addr == held_addr && mem_tag == held_tag, "R9",
              "stalled request held", mem_addr, held_addr);
        for (int k = 1; k <= 8; k++) expect_out(4'(k + 1), 1'(k % 2), "R5");
        @(negedge clk);
        mem_ready = 1'b1;
        drain(60);
        #5;
        check(in_ready == 1'b1, "R8", "space after drain", in_ready, 1);
        check(mem_valid == 1'b0, "R6", "idle after drain", mem_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule